// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar date in seven packed-BCD registers. A one-cycle strobe, asserted once per second by a timebase elsewhere on the chip, advances the seconds. Carries ripple from the seconds through the minutes and hours into the weekday, the day of the month, the month and a two-digit year. A century flag sits in the month register and toggles when the year rolls over. The hour register counts either 0 to 23 or 1 to 12 with a PM flag. A control bit chooses between the two, and the count does not convert the stored hour when that bit changes.

A host-interface block reaches the registers through an addressed write port and a registered read port. A wide load strobe sets all seven time fields in one cycle, so a set-time operation can never be split by a carry. A stop flag stands for an oscillator that has not yet run or has failed. Reset and a failure input set the flag. While it is set, the counters hold their values. The host clears it by writing a zero to its bit.

Top module: `rtcal_core`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x81, year 0x00. The mode register reads 0x20 (24-hour mode) and the status register reads 0x10 (stopped).
- R2: The read port returns, one clock after the address is presented, the register selected by the address. Addresses 0..6 hold seconds, minutes, hours, weekday, day, month, year. Address 14 holds the 24-hour bit in bit 5. Address 15 holds the stop flag in bit 4. All other addresses and all unimplemented bits read 0.
- R3: On an accepted tick, seconds step in BCD and wrap from 0x59 to 0x00 with a carry into the minutes. Minutes wrap from 0x59 to 0x00 with a carry into the hours.
- R4: In 24-hour mode the hour steps in BCD from 0x00 to 0x23. A carry out of 0x23 returns it to 0x00 and advances the day.
- R5: In 12-hour mode bit 5 of the hour register is PM and bits 4:0 hold a BCD hour from 1 to 12. A carry at 11 moves to 12 and toggles PM. The day advances only when PM goes from set to clear. From 12 the hour goes to 01 with PM unchanged. Midnight is 0x12 and noon is 0x32.
- R6: The day wraps to 0x01 and carries into the month after the last day of the month. April, June, September and November have 30 days. February has 29 days when the binary value of the BCD year is a multiple of 4, and 28 days otherwise. All other months have 31 days.
- R7: The weekday advances with every day carry and wraps from 6 to 0.
- R8: The month wraps from 0x12 to 0x01 with a carry into the year. The year wraps from 0x99 to 0x00 and toggles the century flag in bit 7 of the month register.
- R9: Reset and the oscillator-failure input set the stop flag. A host write to address 15 with bit 4 clear clears the flag. A write with bit 4 set leaves it unchanged. A failure in the same cycle as a clearing write leaves the flag set.
- R10: While the stop flag is set, ticks change no time register.
- R11: A host write to addresses 0..6 or 14 is visible from the next clock. The value is masked to the implemented bits: 0x7F seconds, 0x7F minutes, 0x3F hours, 0x07 weekday, 0x3F day, 0x9F month, 0xFF year. Writes to addresses 7..13 have no effect.
- R12: The load strobe copies all seven time registers at once from the load bus, with byte k (bits 8k+7:8k) going to address k, masked as in R11. When load and write fall in the same cycle, load wins.
- R13: A tick that falls in the same cycle as any host write or load is discarded. Only the host's value lands and no field advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle once-per-second advance strobe |
| osc_fail_i | input | 1 | Oscillator loss indication, sets the stop flag |
| wr_en_i | input | 1 | Host register write enable |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | 8 | Host write data |
| load_i | input | 1 | Load all seven time registers from the load bus |
| load_data_i | input | 56 | Packed time fields, byte k for address k |
| rd_addr_i | input | ADDR_W | Host read address |
| rd_data_o | output | 8 | Registered read data |

## Verification
A once-per-second tick can land in the same cycle as a host write or a full load. The design drops the tick in favour of the host. The bench forces this by raising the tick together with a write to a field that is about to carry, and together with the load strobe. It then reads back every register and compares it with a model in which only the host's value took effect. Random runs also mix ticks with writes in both hour modes, while loads place the counters just short of minute, day, month and year boundaries.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

  localparam int FIELD_CNT  = 7;
  localparam int BYTE_W     = 8;
  localparam int IDX_W      = $clog2(FIELD_CNT);

  localparam int PM_BIT     = 5;
  localparam int CENT_BIT   = 7;
  localparam int MODE24_BIT = 5;
  localparam int STOP_BIT   = 4;

  typedef enum int {
    F_SEC  = 0,
    F_MIN  = 1,
    F_HOUR = 2,
    F_WDAY = 3,
    F_DAY  = 4,
    F_MON  = 5,
    F_YEAR = 6
  } field_e;

  function automatic logic [BYTE_W-1:0] field_mask(int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h7F;
      F_HOUR, F_DAY: return 8'h3F;
      F_WDAY:       return 8'h07;
      F_MON:        return 8'h9F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] field_init(int idx);
    case (idx)
      F_DAY:   return 8'h01;
      F_MON:   return 8'h81;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] bcd_inc(logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

endpackage

// File: rtl/rtcal_bcd_step.sv
module rtcal_bcd_step
  import rtcal_pkg::*;
(
  input  logic              en_i,
  input  logic [BYTE_W-1:0] val_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  output logic [BYTE_W-1:0] nxt_o,
  output logic              carry_o
);

  always_comb begin
    nxt_o   = val_i;
    carry_o = 1'b0;
    if (en_i) begin
      if (val_i >= hi_i) begin
        nxt_o   = lo_i;
        carry_o = 1'b1;
      end else begin
        nxt_o = bcd_inc(val_i);
      end
    end
  end

endmodule

// File: rtl/rtcal_hour_step.sv
module rtcal_hour_step
  import rtcal_pkg::*;
(
  input  logic              en_i,
  input  logic              mode24_i,
  input  logic [BYTE_W-1:0] val_i,
  output logic [BYTE_W-1:0] nxt_o,
  output logic              carry_o
);

  logic [4:0] h12;
  logic       pm;

  assign h12 = val_i[4:0];
  assign pm  = val_i[PM_BIT];

  always_comb begin
    nxt_o   = val_i;
    carry_o = 1'b0;
    if (en_i) begin
      if (mode24_i) begin
        if (val_i >= 8'h23) begin
          nxt_o   = 8'h00;
          carry_o = 1'b1;
        end else begin
          nxt_o = bcd_inc(val_i);
        end
      end else begin
        if (h12 >= 5'h12) begin
          nxt_o = {2'b00, pm, 5'h01};
        end else if (h12 == 5'h11) begin
          nxt_o   = {2'b00, ~pm, 5'h12};
          carry_o = pm;
        end else begin
          nxt_o = {2'b00, pm, 5'(bcd_inc({3'b000, h12}))};
        end
      end
    end
  end

endmodule

// File: rtl/rtcal_month_len.sv
module rtcal_month_len
  import rtcal_pkg::*;
(
  input  logic [4:0]        month_i,
  input  logic [BYTE_W-1:0] year_i,
  output logic [BYTE_W-1:0] last_day_o
);

  logic [3:0] tens;
  logic [3:0] ones;
  logic       leap;

  assign tens = year_i[7:4];
  assign ones = year_i[3:0];

  always_comb begin
    if (!tens[0]) leap = (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    else          leap = (ones == 4'd2) || (ones == 4'd6);
  end

  always_comb begin
    case (month_i)
      5'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end

endmodule

// File: rtl/rtcal_core.sv
module rtcal_core
  import rtcal_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MODE_ADDR = 14,
  parameter int STAT_ADDR = 15
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick_i,
  input  logic                        osc_fail_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [BYTE_W-1:0]           wr_data_i,
  input  logic                        load_i,
  input  logic [FIELD_CNT*BYTE_W-1:0] load_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [BYTE_W-1:0]           rd_data_o
);

  localparam int FLAT_W = FIELD_CNT * BYTE_W;

  logic [BYTE_W-1:0] time_q [FIELD_CNT];
  logic [BYTE_W-1:0] step_d [FIELD_CNT];
  logic [FLAT_W-1:0] time_flat;
  logic              mode24_q;
  logic              stop_q;

  logic host_act;
  logic run_tick;
  logic c_sec, c_min, c_hour, c_day, c_mon, c_year;
  logic [BYTE_W-1:0] day_last;
  logic [BYTE_W-1:0] mon_nxt;

  assign host_act = wr_en_i | load_i;
  assign run_tick = tick_i & ~stop_q & ~host_act;

  // counting chain
  rtcal_bcd_step u_sec (
    .en_i(run_tick), .val_i(time_q[F_SEC]), .lo_i(8'h00), .hi_i(8'h59),
    .nxt_o(step_d[F_SEC]), .carry_o(c_sec)
  );

  rtcal_bcd_step u_min (
    .en_i(c_sec), .val_i(time_q[F_MIN]), .lo_i(8'h00), .hi_i(8'h59),
    .nxt_o(step_d[F_MIN]), .carry_o(c_min)
  );

  rtcal_hour_step u_hour (
    .en_i(c_min), .mode24_i(mode24_q), .val_i(time_q[F_HOUR]),
    .nxt_o(step_d[F_HOUR]), .carry_o(c_hour)
  );

  logic c_wday_unused;
  rtcal_bcd_step u_wday (
    .en_i(c_hour), .val_i(time_q[F_WDAY]), .lo_i(8'h00), .hi_i(8'h06),
    .nxt_o(step_d[F_WDAY]), .carry_o(c_wday_unused)
  );

  rtcal_month_len u_len (
    .month_i(time_q[F_MON][4:0]), .year_i(time_q[F_YEAR]), .last_day_o(day_last)
  );

  rtcal_bcd_step u_day (
    .en_i(c_hour), .val_i(time_q[F_DAY]), .lo_i(8'h01), .hi_i(day_last),
    .nxt_o(step_d[F_DAY]), .carry_o(c_day)
  );

  rtcal_bcd_step u_mon (
    .en_i(c_day), .val_i({3'b000, time_q[F_MON][4:0]}), .lo_i(8'h01), .hi_i(8'h12),
    .nxt_o(mon_nxt), .carry_o(c_mon)
  );

  rtcal_bcd_step u_year (
    .en_i(c_mon), .val_i(time_q[F_YEAR]), .lo_i(8'h00), .hi_i(8'h99),
    .nxt_o(step_d[F_YEAR]), .carry_o(c_year)
  );

  assign step_d[F_MON] = {time_q[F_MON][CENT_BIT] ^ c_year, 2'b00, mon_nxt[4:0]};

  // time registers
  always_ff @(posedge clk) begin
    for (int k = 0; k < FIELD_CNT; k++) begin
      if (rst)
        time_q[k] <= field_init(k);
      else if (load_i)
        time_q[k] <= load_data_i[k*BYTE_W +: BYTE_W] & field_mask(k);
      else if (wr_en_i && wr_addr_i == ADDR_W'(k))
        time_q[k] <= wr_data_i & field_mask(k);
      else
        time_q[k] <= step_d[k];
    end
  end

  generate
    for (genvar g = 0; g < FIELD_CNT; g++) begin : g_flat
      assign time_flat[g*BYTE_W +: BYTE_W] = time_q[g];
    end
  endgenerate

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode24_q <= 1'b1;
      stop_q   <= 1'b1;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_W'(MODE_ADDR))
        mode24_q <= wr_data_i[MODE24_BIT];
      if (osc_fail_i)
        stop_q <= 1'b1;
      else if (wr_en_i && wr_addr_i == ADDR_W'(STAT_ADDR) && !wr_data_i[STOP_BIT])
        stop_q <= 1'b0;
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      rd_data_o <= '0;
      if (rd_addr_i < ADDR_W'(FIELD_CNT))
        rd_data_o <= time_q[rd_addr_i[IDX_W-1:0]];
      else if (rd_addr_i == ADDR_W'(MODE_ADDR))
        rd_data_o[MODE24_BIT] <= mode24_q;
      else if (rd_addr_i == ADDR_W'(STAT_ADDR))
        rd_data_o[STOP_BIT] <= stop_q;
    end
  end

endmodule

// File: rtl/rtcal_core_chk.sv
module rtcal_core_chk
  import rtcal_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 15
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        tick_i,
  input logic                        osc_fail_i,
  input logic                        wr_en_i,
  input logic [ADDR_W-1:0]           wr_addr_i,
  input logic [BYTE_W-1:0]           wr_data_i,
  input logic                        load_i,
  input logic [FIELD_CNT*BYTE_W-1:0] load_data_i,
  input logic                        stop_q,
  input logic [FIELD_CNT*BYTE_W-1:0] time_flat
);

  localparam logic [FIELD_CNT*BYTE_W-1:0] LOAD_MASK = 56'hFF_9F_3F_07_3F_7F_7F;

  a_r10_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !wr_en_i && !load_i) |=> $stable(time_flat));

  a_r9_fail_sets_stop: assert property (@(posedge clk) disable iff (rst)
    osc_fail_i |=> stop_q);

  a_r9_write_clears_stop: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == ADDR_W'(STAT_ADDR) && !wr_data_i[STOP_BIT] && !osc_fail_i)
      |=> !stop_q);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !wr_en_i && !load_i) |=> $stable(time_flat));

  a_r12_load_lands: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (time_flat == ($past(load_data_i) & LOAD_MASK)));

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !stop_q && !wr_en_i && !load_i && time_flat[7:0] == 8'h59)
      |=> (time_flat[7:0] == 8'h00));

endmodule

bind rtcal_core rtcal_core_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .osc_fail_i(osc_fail_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .load_i(load_i), .load_data_i(load_data_i), .stop_q(stop_q), .time_flat(time_flat)
);

// File: tb/rtcal_core_bench.sv
module rtcal_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        osc_fail_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        load_i = 1'b0;
  logic [55:0] load_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;

  int checks = 0;
  int errors = 0;

  // model in binary
  int m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_yr, m_cent, m_h24, m_stop;

  always #5 clk = ~clk;

  rtcal_core u_rtcal_core (
    .clk(clk), .rst(rst), .tick_i(tick_i), .osc_fail_i(osc_fail_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .load_i(load_i), .load_data_i(load_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int last_day(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc(int idx);
    case (idx)
      0: return bcd(m_sec);
      1: return bcd(m_min);
      2: begin
        if (m_h24 != 0) return bcd(m_hr);
        return ((m_hr >= 12) ? 8'h20 : 8'h00) | bcd((m_hr + 11) % 12 + 1);
      end
      3: return bcd(m_wd);
      4: return bcd(m_day);
      5: return ((m_cent != 0) ? 8'h80 : 8'h00) | bcd(m_mon);
      6: return bcd(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [55:0] enc_all();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[k*8 +: 8] = enc(k);
    return v;
  endfunction

  task automatic model_tick();
    if (m_stop != 0) return;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd + 1) % 7;
    if (m_day < last_day(m_mon, m_yr)) begin m_day++; return; end
    m_day = 1; m_mon++;
    if (m_mon < 13) return;
    m_mon = 1; m_yr++;
    if (m_yr < 100) return;
    m_yr = 0; m_cent = 1 - m_cent;
  endtask

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr_i = a;
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic check_all(string req);
    logic [7:0] d;
    for (int k = 0; k < 7; k++) begin
      rd(4'(k), d);
      check(req, $sformatf("reg%0d", k), d, enc(k));
    end
    rd(4'd14, d);
    check(req, "mode", d, (m_h24 != 0) ? 8'h20 : 8'h00);
    rd(4'd15, d);
    check(req, "stop", d, (m_stop != 0) ? 8'h10 : 8'h00);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    model_tick();
  endtask

  task automatic load_raw(input logic [55:0] v);
    @(negedge clk);
    load_i = 1'b1; load_data_i = v;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic set_time(int s, int mi, int h, int wd, int dy, int mo, int yr, int c);
    m_sec = s; m_min = mi; m_hr = h; m_wd = wd; m_day = dy; m_mon = mo; m_yr = yr; m_cent = c;
    load_raw(enc_all());
  endtask

  task automatic set_mode(int h24);
    wr(4'd14, (h24 != 0) ? 8'h20 : 8'h00);
    m_h24 = h24;
    wr(4'd2, enc(2));
  endtask

  function automatic int pick(int hi, int edge_v);
    if ($urandom_range(3) == 0) return edge_v;
    return int'($urandom_range(hi));
  endfunction

  task automatic random_phase(int n);
    for (int i = 0; i < n; i++) begin
      int op;
      op = int'($urandom_range(9));
      if (op < 5) begin
        do_tick();
      end else if (op < 7 || op == 9) begin
        int idx;
        idx = int'($urandom_range(6));
        case (idx)
          0: m_sec = pick(59, 59);
          1: m_min = pick(59, 59);
          2: m_hr  = pick(23, 23);
          3: m_wd  = pick(6, 6);
          4: m_day = 1 + int'($urandom_range(27));
          5: m_mon = 1 + pick(11, 11);
          default: m_yr = pick(99, 99);
        endcase
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 4'(idx); wr_data_i = enc(idx);
        tick_i = (op == 9);
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
      end else begin
        int mo;
        mo = 1 + int'($urandom_range(11));
        m_yr = pick(99, 99);
        m_day = ($urandom_range(1) == 0) ? last_day(mo, m_yr) : 1 + int'($urandom_range(27));
        set_time(pick(59, 59), pick(59, 59), pick(23, 23), pick(6, 6), m_day, mo, m_yr,
                 int'($urandom_range(1)));
      end
      check_all("R3");
    end
  endtask

  task automatic day_corner(int dy, int mo, int yr, string req);
    set_time(59, 59, 23, 2, dy, mo, yr, 1);
    do_tick();
    check_all(req);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_day = 1; m_mon = 1; m_yr = 0;
    m_cent = 1; m_h24 = 1; m_stop = 1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values, R2 unused addresses
    check_all("R1");
    rd(4'd7, d);  check("R2", "addr7", d, 8'h00);
    rd(4'd12, d); check("R2", "addr12", d, 8'h00);

    // R10 ticks ignored while stopped
    do_tick(); do_tick();
    check_all("R10");

    // R9 writing 1 leaves the flag set, writing 0 clears it
    wr(4'd15, 8'hFF);
    check_all("R9");
    wr(4'd15, 8'h00); m_stop = 0;
    check_all("R9");
    wr(4'd15, 8'h10);
    check_all("R9");

    // R3 seconds and minutes carry
    set_time(58, 59, 10, 1, 5, 3, 21, 1);
    do_tick(); check_all("R3");
    do_tick(); check_all("R3");
    rd(4'd2, d); check("R3", "hour literal", d, 8'h11);

    // R4 R7 R8 full rollover
    set_time(59, 59, 23, 6, 31, 12, 99, 0);
    do_tick(); check_all("R8");
    rd(4'd5, d); check("R8", "month literal", d, 8'h81);
    rd(4'd3, d); check("R7", "weekday literal", d, 8'h00);
    rd(4'd2, d); check("R4", "hour literal", d, 8'h00);

    // R6 month lengths
    day_corner(28, 2, 24, "R6");
    day_corner(29, 2, 24, "R6");
    day_corner(28, 2, 23, "R6");
    day_corner(28, 2, 0, "R6");
    day_corner(30, 4, 50, "R6");
    day_corner(30, 1, 50, "R6");
    day_corner(31, 1, 50, "R6");
    day_corner(30, 11, 7, "R6");
    rd(4'd4, d); check("R6", "day literal", d, 8'h01);

    // R11 masking and ignored addresses
    wr(4'd0, 8'hFF);
    rd(4'd0, d); check("R11", "sec mask", d, 8'h7F);
    wr(4'd5, 8'hFF);
    rd(4'd5, d); check("R11", "month mask", d, 8'h9F);
    set_time(10, 20, 5, 3, 9, 8, 40, 1);
    wr(4'd9, 8'hAA);
    wr(4'd7, 8'h55);
    rd(4'd9, d); check("R11", "addr9", d, 8'h00);
    check_all("R11");

    // R12 masked load
    load_raw({8{8'hFF}});
    rd(4'd0, d); check("R12", "sec", d, 8'h7F);
    rd(4'd2, d); check("R12", "hour", d, 8'h3F);
    rd(4'd3, d); check("R12", "wday", d, 8'h07);
    rd(4'd5, d); check("R12", "month", d, 8'h9F);
    rd(4'd6, d); check("R12", "year", d, 8'hFF);

    // R13 tick collides with write and with load
    set_time(59, 59, 23, 4, 31, 12, 99, 1);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 4'd3; wr_data_i = 8'h02;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    m_wd = 2;
    check_all("R13");
    m_sec = 59; m_min = 59; m_hr = 7;
    @(negedge clk);
    tick_i = 1'b1; load_i = 1'b1; load_data_i = enc_all();
    @(negedge clk);
    tick_i = 1'b0; load_i = 1'b0;
    check_all("R13");
    rd(4'd0, d); check("R13", "sec literal", d, 8'h59);

    // R9 failure sets flag; failure beats clear; R10 again
    @(negedge clk); osc_fail_i = 1'b1;
    @(negedge clk); osc_fail_i = 1'b0;
    m_stop = 1;
    do_tick();
    check_all("R10");
    @(negedge clk);
    osc_fail_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 4'd15; wr_data_i = 8'h00;
    @(negedge clk);
    osc_fail_i = 1'b0; wr_en_i = 1'b0;
    check_all("R9");
    wr(4'd15, 8'h00); m_stop = 0;

    // R5 12-hour mode
    set_mode(0);
    set_time(59, 59, 11, 1, 10, 5, 30, 1);
    do_tick(); check_all("R5");
    rd(4'd2, d); check("R5", "noon", d, 8'h32);
    set_time(59, 59, 23, 1, 10, 5, 30, 1);
    do_tick(); check_all("R5");
    rd(4'd2, d); check("R5", "midnight", d, 8'h12);
    set_time(59, 59, 12, 1, 10, 5, 30, 1);
    do_tick(); check_all("R5");
    rd(4'd2, d); check("R5", "one pm", d, 8'h21);
    set_time(59, 59, 0, 1, 10, 5, 30, 1);
    do_tick(); check_all("R5");
    rd(4'd2, d); check("R5", "one am", d, 8'h01);
    rd(4'd14, d); check("R2", "mode 12h", d, 8'h00);

    // random phases in both modes
    random_phase(250);
    set_mode(1);
    random_phase(250);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule